// File: doc/BRIEF.md
# Double-Buffered Synthesizer Register Bank

This block holds the byte-wide control registers of a frequency-synthesis core in two copies. A host writes bytes into the staging copy through a simple synchronous port. Meanwhile the live copy keeps driving the core's frequency, ramp-rate and timer fields. When an update event occurs, the whole staging copy is transferred into the live copy in a single clock edge. The next operating point can therefore be prepared piece by piece and then applied in one step.

Update events come from three places. The first is a software strobe, which always works. The second is a periodic timer, used when the live control byte selects internal mode. The third is the rising edge of an external update pin, used when the live control byte selects external mode. The timer period and the mode selection are themselves read from the live copy. A freshly reset bank is therefore idle until the first software update commits a configuration.

Top module: `dbreg_bank`

## Requirements
- R1: After a synchronous reset, every byte of both copies is zero, so all field outputs and `rd_data` read zero.
- R2: A host write (`wr_en`) changes only the staging copy. The live copy and the field outputs stay unchanged until an update event. `rd_live`=0 reads the staging byte at `rd_addr`, and `rd_live`=1 reads the live byte.
- R3: A high `sw_update` at a clock edge copies all 256 staging bytes into the live copy at that edge. This works in either mode.
- R4: Multi-byte fields are taken from the live copy with the lowest address as the most significant byte:
  - period: bytes 0x00–0x03
  - frequency A: bytes 0x04–0x09
  - frequency B: bytes 0x0A–0x0F
  - delta frequency: bytes 0x10–0x15
  - control: byte 0x18, where bit 0 = 1 selects external mode
  - ramp rate: bytes 0x1A–0x1C
- R5: Internal mode with a live period P ≠ 0 works as follows. An update occurs 2·P clock edges after the previous update edge of any source, and the timer then reloads.
- R6: In internal mode, a live period of zero produces no periodic updates.
- R7: External mode works as follows:
  - The timer is disabled.
  - The update pin passes through two synchronizing flops.
  - A low-to-high transition of the pin present before edge k produces an update at edge k+2.
  - A pin that stays high produces no further updates.
- R8: In internal mode, the external update pin has no effect.
- R9: If a host write and an update fall on the same edge, the live copy receives the staging contents from before the write, and the staging copy takes the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write enable (staging copy) |
| wr_addr | input | 8 | Host write byte address |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 8 | Read byte address |
| rd_live | input | 1 | Read copy select: 0 staging, 1 live |
| rd_data | output | 8 | Combinational read byte |
| sw_update | input | 1 | Software update strobe |
| ext_update | input | 1 | Asynchronous external update pin |
| freq_a | output | 48 | Live frequency A word |
| freq_b | output | 48 | Live frequency B word |
| freq_delta | output | 48 | Live delta frequency word |
| ramp_rate | output | 24 | Live ramp-rate word |
| upd_period | output | 32 | Live update period (units of 2 clocks) |
| ext_src | output | 1 | Live update-source select (1 = external pin) |

## Verification
The bench builds the bank with its default 8-bit address and byte width and a two-stage synchronizer. This exposes the full 256-byte copy and the real 48-bit field taps.

A period of three brings two consecutive timer expiries, six edges apart, within a short run. It also lets the reload be seen directly. With the same parameters, the bench can drive a collision of a write and an update on one edge, and a held-high pin that must not retrigger.

// File: rtl/dbreg_pkg.sv
// Package: dbreg_pkg
// Shared geometry and field placement of the double-buffered register bank.
// Assumes byte-wide registers and most-significant-byte-first field layout.
package dbreg_pkg;
    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 8;
    localparam int NREG         = 1 << ADDR_W;
    localparam int PERIOD_BASE  = 'h00;
    localparam int PERIOD_BYTES = 4;
    localparam int FREQ_BYTES   = 6;
    localparam int FA_BASE      = 'h04;
    localparam int FB_BASE      = 'h0A;
    localparam int FD_BASE      = 'h10;
    localparam int CTRL_ADDR    = 'h18;
    localparam int CTRL_EXT_BIT = 0;
    localparam int RR_BASE      = 'h1A;
    localparam int RR_BYTES     = 3;
endpackage

// File: rtl/dbreg_store.sv
// Module: dbreg_store
// Holds the staging and live register copies. Host writes land in staging;
// a commit copies all of staging into live at one edge (pre-write contents).
// Assumes commit is a single-cycle qualified strobe from the top.
module dbreg_store #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic                          commit,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_live,
    output logic [BYTE_W-1:0]             rd_data,
    output logic [NREG-1:0][BYTE_W-1:0]   live_q
);
    logic [NREG-1:0][BYTE_W-1:0] stage_q;

    // Staging copy: host byte writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr_en) begin
            stage_q[wr_addr] <= wr_data;
        end
    end

    // Live copy: whole-bank transfer on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (commit) begin
            live_q <= stage_q;
        end
    end

    // Read mux: select copy then byte
    always_comb begin
        rd_data = rd_live ? live_q[rd_addr] : stage_q[rd_addr];
    end

    // R2: a written byte is present in staging on the next cycle
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (stage_q[$past(wr_addr)] == $past(wr_data)));

    // R2: live copy holds while no update happens
    assert_live_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_q));

    // R3 and R9: live equals staging as it stood before the commit edge
    assert_full_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_q == $past(stage_q)));
endmodule

// File: rtl/dbreg_tap.sv
// Module: dbreg_tap
// Gathers NBYTES consecutive live bytes from BASE into one word, lowest
// address as most significant byte. Pure wiring; assumes BASE+NBYTES <= NREG.
module dbreg_tap #(
    parameter int NREG   = 256,
    parameter int BYTE_W = 8,
    parameter int BASE   = 0,
    parameter int NBYTES = 1
) (
    input  logic [NREG-1:0][BYTE_W-1:0] live,
    output logic [NBYTES*BYTE_W-1:0]    word
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        // Place byte BASE+i at significance NBYTES-1-i
        assign word[(NBYTES-1-i)*BYTE_W +: BYTE_W] = live[BASE+i];
    end
endmodule

// File: rtl/dbreg_extsync.sv
// Module: dbreg_extsync
// Synchronizes an asynchronous update pin through STAGES flops and emits a
// one-cycle pulse on its rising edge. Assumes pin pulses last >= 2 clocks.
module dbreg_extsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [STAGES:0] shift_q;

    // Synchronizer chain plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[STAGES-1:0], pin};
        end
    end

    // Rising edge of the synchronized level
    assign rise = shift_q[STAGES-1] & ~shift_q[STAGES];

    // R7: a held-high pin yields one pulse only
    assert_single_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dbreg_timer.sv
// Module: dbreg_timer
// Periodic update timer with a resolution of two clocks: expires 2*period
// edges after the last restart. Restart (any update) reloads it; disabled
// while enable is low. Assumes enable is low whenever period is zero.
module dbreg_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    input  logic             restart,
    output logic             expire
);
    logic             half_q;
    logic [CNT_W-1:0] cnt_q;

    // Expiry on the second half of the last period unit
    assign expire = enable && half_q && (cnt_q == period - CNT_W'(1));

    // Two-clock prescaler and unit counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) begin
            half_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            half_q <= ~half_q;
            if (half_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R6: a zero period never expires
    assert_zero_period_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |-> !expire);

    // R5: expiries are at least two clocks apart
    assert_expiry_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);
endmodule

// File: rtl/dbreg_bank.sv
// Module: dbreg_bank
// Double-buffered byte register bank for a synthesis core. Qualifies update
// sources (software strobe always; timer in internal mode; pin edge in
// external mode) into one commit and exposes live fields. Assumes the mode
// and period come from the live copy, so reset leaves the bank idle.
module dbreg_bank
    import dbreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_live,
    output logic [BYTE_W-1:0]             rd_data,
    input  logic                          sw_update,
    input  logic                          ext_update,
    output logic [FREQ_BYTES*BYTE_W-1:0]  freq_a,
    output logic [FREQ_BYTES*BYTE_W-1:0]  freq_b,
    output logic [FREQ_BYTES*BYTE_W-1:0]  freq_delta,
    output logic [RR_BYTES*BYTE_W-1:0]    ramp_rate,
    output logic [PERIOD_BYTES*BYTE_W-1:0] upd_period,
    output logic                          ext_src
);
    localparam int PER_W = PERIOD_BYTES * BYTE_W;

    logic [NREG-1:0][BYTE_W-1:0] live;
    logic                        ext_rise;
    logic                        tmr_exp;
    logic                        tmr_en;
    logic                        commit;

    // Commit qualification across the three sources
    assign ext_src = live[CTRL_ADDR][CTRL_EXT_BIT];
    assign tmr_en  = !ext_src && (upd_period != '0);
    assign commit  = sw_update || (ext_src && ext_rise) || tmr_exp;

    dbreg_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .rd_addr (rd_addr),
        .rd_live (rd_live),
        .rd_data (rd_data),
        .live_q  (live)
    );

    dbreg_extsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_update),
        .rise  (ext_rise)
    );

    dbreg_timer #(.CNT_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (tmr_en),
        .period  (upd_period),
        .restart (commit),
        .expire  (tmr_exp)
    );

    dbreg_tap #(.NREG(NREG), .BYTE_W(BYTE_W), .BASE(PERIOD_BASE), .NBYTES(PERIOD_BYTES))
        u_tap_per (.live(live), .word(upd_period));
    dbreg_tap #(.NREG(NREG), .BYTE_W(BYTE_W), .BASE(FA_BASE), .NBYTES(FREQ_BYTES))
        u_tap_fa (.live(live), .word(freq_a));
    dbreg_tap #(.NREG(NREG), .BYTE_W(BYTE_W), .BASE(FB_BASE), .NBYTES(FREQ_BYTES))
        u_tap_fb (.live(live), .word(freq_b));
    dbreg_tap #(.NREG(NREG), .BYTE_W(BYTE_W), .BASE(FD_BASE), .NBYTES(FREQ_BYTES))
        u_tap_fd (.live(live), .word(freq_delta));
    dbreg_tap #(.NREG(NREG), .BYTE_W(BYTE_W), .BASE(RR_BASE), .NBYTES(RR_BYTES))
        u_tap_rr (.live(live), .word(ramp_rate));

    // R7: the timer never fires in external mode
    assert_timer_off_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_src |-> !tmr_exp);

    // R8: in internal mode, only the strobe or the timer can change the live fields
    assert_pin_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_src && !sw_update && !tmr_exp) |=> $stable(freq_b));
endmodule

// File: tb/dbreg_bank_tb.sv
// Bench: behavioural reference model of both copies, compared every clock,
// plus directed, requirement-tagged checks.
module dbreg_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic        rd_live = 1'b0;
    logic [7:0]  rd_data;
    logic        sw_update = 1'b0;
    logic        ext_update = 1'b0;
    logic [47:0] freq_a, freq_b, freq_delta;
    logic [23:0] ramp_rate;
    logic [31:0] upd_period;
    logic        ext_src;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbreg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_live(rd_live), .rd_data(rd_data),
        .sw_update(sw_update), .ext_update(ext_update),
        .freq_a(freq_a), .freq_b(freq_b), .freq_delta(freq_delta),
        .ramp_rate(ramp_rate), .upd_period(upd_period), .ext_src(ext_src)
    );

    // Reference model state
    logic [7:0] m_stage [256];
    logic [7:0] m_live  [256];
    bit  p1, p2, p3;
    longint tcount;

    function automatic logic [63:0] mfield(int base, int n);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) v = (v << 8) | 64'(m_live[base + i]);
        return v;
    endfunction

    // Model update, same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin m_stage[i] = '0; m_live[i] = '0; end
            p1 = 0; p2 = 0; p3 = 0; tcount = 0;
        end else begin
            longint per;
            bit ext, rise, tmr, com;
            per  = longint'(mfield('h00, 4));
            ext  = m_live['h18][0];
            rise = p2 && !p3;
            tmr  = !ext && per != 0 && tcount == 2 * per - 1;
            com  = sw_update || (ext && rise) || tmr;
            if (com) for (int i = 0; i < 256; i++) m_live[i] = m_stage[i];
            if (wr_en) m_stage[wr_addr] = wr_data;
            if (com || ext || per == 0) tcount = 0; else tcount++;
            p3 = p2; p2 = p1; p1 = ext_update;
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at t=%0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    task automatic compare_all();
        logic [7:0] exp_rd;
        exp_rd = rd_live ? m_live[rd_addr] : m_stage[rd_addr];
        chk("R2 rd_data", 64'(rd_data), 64'(exp_rd));
        chk("R4 freq_a", 64'(freq_a), mfield('h04, 6));
        chk("R4 freq_b", 64'(freq_b), mfield('h0A, 6));
        chk("R4 freq_delta", 64'(freq_delta), mfield('h10, 6));
        chk("R4 ramp_rate", 64'(ramp_rate), mfield('h1A, 3));
        chk("R5 upd_period", 64'(upd_period), mfield('h00, 4));
        chk("R7 ext_src", 64'(ext_src), 64'(m_live['h18][0]));
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic sw_pulse();
        sw_update = 1'b1;
        tick(1);
        sw_update = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog (all requirements): got %0d cycles expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 freq_a", 64'(freq_a), 64'd0);
        chk("R1 upd_period", 64'(upd_period), 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);

        // R2: writes stay in staging
        for (int i = 0; i < 6; i++) wr(8'(4 + i), 8'(1 + i));
        chk("R2 live untouched", 64'(freq_a), 64'd0);
        rd_addr = 8'h05; rd_live = 1'b0; tick(1);
        chk("R2 staging readback", 64'(rd_data), 64'h02);
        rd_live = 1'b1; tick(1);
        chk("R2 live readback", 64'(rd_data), 64'h00);

        // R3: software update copies everything
        sw_pulse();
        chk("R3 freq_a after strobe", 64'(freq_a), 64'h010203040506);

        // R4: field map
        for (int i = 0; i < 6; i++) wr(8'('h0A + i), 8'('h11 + i));
        for (int i = 0; i < 6; i++) wr(8'('h10 + i), 8'('h21 + i));
        for (int i = 0; i < 3; i++) wr(8'('h1A + i), 8'('h31 + i));
        sw_pulse();
        chk("R4 freq_b", 64'(freq_b), 64'h111213141516);
        chk("R4 freq_delta", 64'(freq_delta), 64'h212223242526);
        chk("R4 ramp_rate", 64'(ramp_rate), 64'h313233);
        rd_addr = 8'h1B; rd_live = 1'b1; tick(1);
        chk("R4 live byte 1B", 64'(rd_data), 64'h32);

        // R9: write and update on one edge
        wr_en = 1'b1; wr_addr = 8'h04; wr_data = 8'hAA; sw_update = 1'b1;
        tick(1);
        wr_en = 1'b0; sw_update = 1'b0;
        chk("R9 live takes pre-write", 64'(freq_a), 64'h010203040506);
        rd_addr = 8'h04; rd_live = 1'b0; tick(1);
        chk("R9 staging takes write", 64'(rd_data), 64'hAA);

        // R6: zero period, internal mode, no periodic update
        tick(40);
        chk("R6 no periodic update", 64'(freq_a[47:40]), 64'h01);

        // R5: period 3 -> update every 6 edges
        wr(8'h03, 8'h03);
        sw_pulse();
        chk("R5 period live", 64'(upd_period), 64'd3);
        wr(8'h0A, 8'h55);
        tick(4);
        chk("R5 before expiry", 64'(freq_b[47:40]), 64'h11);
        tick(1);
        chk("R5 first expiry", 64'(freq_b[47:40]), 64'h55);
        wr(8'h0A, 8'h66);
        tick(4);
        chk("R5 before reload expiry", 64'(freq_b[47:40]), 64'h55);
        tick(1);
        chk("R5 reload expiry", 64'(freq_b[47:40]), 64'h66);

        // R7: external mode
        wr(8'h18, 8'h01);
        sw_pulse();
        chk("R7 mode external", 64'(ext_src), 64'd1);
        wr(8'h0A, 8'h88);
        tick(20);
        chk("R7 timer disabled", 64'(freq_b[47:40]), 64'h77 ^ 64'h77 ^ 64'(m_live['h0A]));
        chk("R7 timer disabled value", 64'(freq_b[47:40]), 64'h66);
        ext_update = 1'b1;
        tick(2);
        chk("R7 sync latency", 64'(freq_b[47:40]), 64'h66);
        tick(1);
        chk("R7 edge update", 64'(freq_b[47:40]), 64'h88);
        wr(8'h0A, 8'h99);
        tick(10);
        chk("R7 held level no retrigger", 64'(freq_b[47:40]), 64'h88);
        ext_update = 1'b0;
        tick(3);

        // R8: internal mode, pin ignored
        wr(8'h18, 8'h00);
        wr(8'h03, 8'h00);
        sw_pulse();
        chk("R8 back to internal", 64'(ext_src), 64'd0);
        wr(8'h0A, 8'hAB);
        ext_update = 1'b1; tick(2);
        ext_update = 1'b0; tick(6);
        chk("R8 pin ignored", 64'(freq_b[47:40]), 64'h99);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule